// File: doc/BRIEF.md
# Delayed Reset Sequencer

This block turns two active-low reset requests into the reset outputs of a system. One request is the board power-on reset, which may change at any moment with no relation to any clock. The other is a system reset request driven by a debugger. The block runs on a slow, free-running reference clock (nominally 24 MHz).

The power-on reset outputs are plain copies of the board power-on reset, with no register and no delay. The bus reset, the other system resets and a release status all drop as soon as either request goes low, without waiting for a clock edge. When both requests have gone high again, these outputs stay low while the synchronizer fills and a counter runs a programmable number of reference clock cycles. They go high together on a reference clock edge. With the default of 65536 cycles the hold is about 2.7 ms, which gives PLLs and clocks time to settle. Any new request during the hold clears the count, and the count starts again from zero once that request goes away.

Top module: `rst_stretch_seq`

## Requirements
- R1: Every bit of `por_out_n` equals `board_por_n` at all times, with no clock edge involved, and `sys_req_n` has no effect on it.
- R2: While `board_por_n` is 0, `bus_rst_n`, every bit of `sys_rst_n` and `released` are 0, and they fall without a clock edge.
- R3: While `sys_req_n` is 0, `bus_rst_n`, every bit of `sys_rst_n` and `released` are 0, and they fall without a clock edge.
- R4: Once both requests are high, the delayed outputs go to 1 on exactly the (SYNC_STAGES + DELAY_CYCLES)th rising edge of `ref_clk`, and not on an earlier edge.
- R5: A request that arrives before release clears the count, and the release is timed again from the point where that request goes away.
- R6: `bus_rst_n`, every bit of `sys_rst_n` and `released` always carry the same value (1 = released).
- R7: After release, the delayed outputs stay at 1 for as long as both requests stay high.
- R8: A `sys_req_n` low pulse shorter than one `ref_clk` period, with no rising edge inside it, still restarts the full hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock that times the hold |
| board_por_n | input | 1 | Board power-on reset, active low, asynchronous |
| sys_req_n | input | 1 | System reset request from the debugger, active low, asynchronous |
| por_out_n | output | NUM_POR | Power-on reset outputs, copies of `board_por_n` |
| bus_rst_n | output | 1 | Bus reset, active low, held for the delay |
| sys_rst_n | output | NUM_SYS | Other system resets, active low, held for the delay |
| released | output | 1 | High once the hold has finished and the delayed resets are released |

## Verification
The timing assertions assume that `ref_clk` runs without a break, and that the requests change only where the checker's clocked sampling sees them settled. They also assume that a request pulse between edges both clears the block and restarts the checker's own quiet-cycle count. To stay inside these assumptions, the bench changes requests only at falling edges or a few nanoseconds after them, never at a rising edge. It uses a short DELAY_CYCLES, so the windows just before and just at release are both visited many times.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

   // Bits needed to hold every value from 0 up to and including max_val.
   function automatic int unsigned count_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/rstseq_sync.sv
// Shift register that is cleared asynchronously and filled with ones on the
// clock. Its output rises STAGES edges after the clear goes away.
module rstseq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic ref_clk,
   input  logic arst_n,
   output logic sync_n
);
   logic [STAGES-1:0] pipe_q;

   always_ff @(posedge ref_clk or negedge arst_n) begin
      if (!arst_n) pipe_q <= '0;
      else         pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
   end

   assign sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/rstseq_delay_cnt.sv
// Counts reference clock cycles while run is high and sets done on the edge
// where the count reaches DELAY_CYCLES. Both are cleared asynchronously.
module rstseq_delay_cnt #(
   parameter int unsigned DELAY_CYCLES = 65536,
   parameter int unsigned CNT_W        = 17
) (
   input  logic ref_clk,
   input  logic arst_n,
   input  logic run,
   output logic done
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             done_q;

   always_ff @(posedge ref_clk or negedge arst_n) begin
      if (!arst_n) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (run && !done_q) begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == LAST) done_q <= 1'b1;
      end
   end

   assign done = done_q;
endmodule

// File: rtl/rstseq_fanout.sv
// Copies the board reset to the power-on outputs and spreads the done flag
// to all delayed outputs.
module rstseq_fanout #(
   parameter int unsigned NUM_POR = 2,
   parameter int unsigned NUM_SYS = 3
) (
   input  logic               board_por_n,
   input  logic               done,
   output logic [NUM_POR-1:0] por_out_n,
   output logic               bus_rst_n,
   output logic [NUM_SYS-1:0] sys_rst_n,
   output logic               released
);
   for (genvar p = 0; p < NUM_POR; p++) begin : g_por
      assign por_out_n[p] = board_por_n;
   end

   for (genvar s = 0; s < NUM_SYS; s++) begin : g_sys
      assign sys_rst_n[s] = done;
   end

   assign bus_rst_n = done;
   assign released  = done;
endmodule

// File: rtl/rst_stretch_seq.sv
module rst_stretch_seq #(
   parameter int unsigned DELAY_CYCLES = 65536,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned NUM_POR      = 2,
   parameter int unsigned NUM_SYS      = 3
) (
   input  logic               ref_clk,
   input  logic               board_por_n,
   input  logic               sys_req_n,
   output logic [NUM_POR-1:0] por_out_n,
   output logic               bus_rst_n,
   output logic [NUM_SYS-1:0] sys_rst_n,
   output logic               released
);
   import rstseq_pkg::*;

   localparam int unsigned CNT_W = count_width(DELAY_CYCLES);

   if (DELAY_CYCLES < 1) begin : g_bad_delay
      $error("DELAY_CYCLES must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (NUM_POR < 1 || NUM_SYS < 1) begin : g_bad_width
      $error("NUM_POR and NUM_SYS must be at least 1");
   end

   // Either request low clears the whole sequencer at once.
   logic arst_n;
   logic run;
   logic done;

   assign arst_n = board_por_n & sys_req_n;

   rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .ref_clk (ref_clk),
      .arst_n  (arst_n),
      .sync_n  (run)
   );

   rstseq_delay_cnt #(.DELAY_CYCLES(DELAY_CYCLES), .CNT_W(CNT_W)) u_cnt (
      .ref_clk (ref_clk),
      .arst_n  (arst_n),
      .run     (run),
      .done    (done)
   );

   rstseq_fanout #(.NUM_POR(NUM_POR), .NUM_SYS(NUM_SYS)) u_fan (
      .board_por_n (board_por_n),
      .done        (done),
      .por_out_n   (por_out_n),
      .bus_rst_n   (bus_rst_n),
      .sys_rst_n   (sys_rst_n),
      .released    (released)
   );
endmodule

// File: rtl/rst_stretch_seq_checker.sv
module rst_stretch_seq_checker #(
   parameter int unsigned DELAY_CYCLES = 65536,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned NUM_SYS      = 3
) (
   input logic               ref_clk,
   input logic               board_por_n,
   input logic               sys_req_n,
   input logic               bus_rst_n,
   input logic [NUM_SYS-1:0] sys_rst_n,
   input logic               released
);
   localparam int unsigned TOTAL = DELAY_CYCLES + SYNC_STAGES;
   localparam int unsigned QW    = rstseq_pkg::count_width(TOTAL);
   localparam logic [QW-1:0] QMAX = QW'(TOTAL);

   logic          quiet_n;
   logic [QW-1:0] quiet_q;

   assign quiet_n = board_por_n & sys_req_n;

   // Counts the edges since both requests went high, stopping at TOTAL.
   always_ff @(posedge ref_clk or negedge quiet_n) begin
      if (!quiet_n)               quiet_q <= '0;
      else if (quiet_q != QMAX)   quiet_q <= quiet_q + 1'b1;
   end

   a_r2_por_forces: assert property (@(posedge ref_clk)
      !board_por_n |-> (!bus_rst_n && sys_rst_n == '0 && !released));

   a_r3_req_forces: assert property (@(posedge ref_clk)
      !sys_req_n |-> (!bus_rst_n && sys_rst_n == '0 && !released));

   a_r4_not_early: assert property (@(posedge ref_clk) disable iff (!quiet_n)
      released |-> (quiet_q == QMAX));

   a_r7_stays_released: assert property (@(posedge ref_clk) disable iff (!quiet_n)
      (quiet_q == QMAX) |-> released);

   a_r6_outputs_agree: assert property (@(posedge ref_clk) disable iff (!quiet_n)
      (bus_rst_n == released) && (sys_rst_n == {NUM_SYS{released}}));
endmodule

bind rst_stretch_seq rst_stretch_seq_checker #(
   .DELAY_CYCLES (DELAY_CYCLES),
   .SYNC_STAGES  (SYNC_STAGES),
   .NUM_SYS      (NUM_SYS)
) u_chk (
   .ref_clk     (ref_clk),
   .board_por_n (board_por_n),
   .sys_req_n   (sys_req_n),
   .bus_rst_n   (bus_rst_n),
   .sys_rst_n   (sys_rst_n),
   .released    (released)
);

// File: tb/rst_stretch_seq_test.sv
`timescale 1ns/1ps
module rst_stretch_seq_test;
   localparam int unsigned DLY   = 20;
   localparam int unsigned SYNC  = 2;
   localparam int unsigned NP    = 2;
   localparam int unsigned NS    = 3;
   localparam int unsigned TOTAL = DLY + SYNC;

   logic          clk = 1'b0;
   logic          board_por_n = 1'b1;
   logic          sys_req_n = 1'b1;
   logic [NP-1:0] por_out_n;
   logic          bus_rst_n;
   logic [NS-1:0] sys_rst_n;
   logic          released;

   int checks = 0;
   int bad    = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   rst_stretch_seq #(.DELAY_CYCLES(DLY), .SYNC_STAGES(SYNC),
                     .NUM_POR(NP), .NUM_SYS(NS)) uut (
      .ref_clk(clk), .board_por_n(board_por_n), .sys_req_n(sys_req_n),
      .por_out_n(por_out_n), .bus_rst_n(bus_rst_n), .sys_rst_n(sys_rst_n),
      .released(released));

   // vector: [18:17] low mask {por,req}, [16:9] pulse, [8:1] wait, [0] expected
   localparam logic [18:0] VEC [8] = '{
      {2'b10, 8'd3,  8'd21, 1'b0},
      {2'b10, 8'd3,  8'd22, 1'b1},
      {2'b01, 8'd1,  8'd21, 1'b0},
      {2'b01, 8'd1,  8'd22, 1'b1},
      {2'b11, 8'd5,  8'd22, 1'b1},
      {2'b01, 8'd10, 8'd2,  1'b0},
      {2'b10, 8'd1,  8'd0,  1'b0},
      {2'b11, 8'd2,  8'd30, 1'b1}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic negs(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic delayed_all(input string tag, input logic exp);
      chk(tag, {31'd0, bus_rst_n}, {31'd0, exp});
      chk(tag, {29'd0, sys_rst_n}, {29'd0, {NS{exp}}});
      chk(tag, {31'd0, released}, {31'd0, exp});
   endtask

   task automatic settle();
      for (int i = 0; i < 100 && !released; i++) @(negedge clk);
   endtask

   initial begin
      #2;
      board_por_n = 1'b0;
      sys_req_n   = 1'b0;
      #1;
      delayed_all("R2 reset state", 1'b0);
      chk("R1 por low at start", {30'd0, por_out_n}, 32'd0);
      negs(3);
      board_por_n = 1'b1;
      sys_req_n   = 1'b1;
      settle();

      for (int v = 0; v < 8; v++) begin
         @(negedge clk);
         board_por_n = ~VEC[v][18];
         sys_req_n   = ~VEC[v][17];
         #1;
         chk("R1 por copy", {30'd0, por_out_n}, {30'd0, {NP{~VEC[v][18]}}});
         delayed_all(VEC[v][18] ? "R2 vector assert" : "R3 vector assert", 1'b0);
         negs(int'(VEC[v][16:9]));
         board_por_n = 1'b1;
         sys_req_n   = 1'b1;
         negs(int'(VEC[v][8:1]));
         #1;
         delayed_all("R4 R6 vector release", VEC[v][0]);
         if (VEC[v][0]) begin
            negs(10);
            #1;
            delayed_all("R7 stays released", 1'b1);
         end
         settle();
      end

      // Request alone leaves the power-on outputs high, falls without an edge.
      @(negedge clk);
      #1 sys_req_n = 1'b0;
      #1;
      chk("R1 req no effect on por", {30'd0, por_out_n}, {30'd0, {NP{1'b1}}});
      delayed_all("R3 async assert", 1'b0);
      @(negedge clk);
      sys_req_n = 1'b1;
      settle();

      // Board reset mid-cycle reaches the power-on outputs at once.
      @(negedge clk);
      #1 board_por_n = 1'b0;
      #1;
      chk("R1 por async", {30'd0, por_out_n}, 32'd0);
      delayed_all("R2 async assert", 1'b0);
      @(negedge clk);
      board_por_n = 1'b1;
      settle();

      // Restart during the hold with a pulse shorter than a clock period.
      @(negedge clk);
      sys_req_n = 1'b0;
      @(negedge clk);
      sys_req_n = 1'b1;
      negs(15);
      #1;
      delayed_all("R5 still holding", 1'b0);
      #1 sys_req_n = 1'b0;
      #1 sys_req_n = 1'b1;
      negs(21);
      #1;
      delayed_all("R5 R8 restarted not early", 1'b0);
      negs(1);
      #1;
      delayed_all("R5 R8 restarted release", 1'b1);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!finished) begin
         checks++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end
endmodule